// File: doc/BRIEF.md
# Locked Read-Modify-Write Sequencer

This block performs indivisible memory updates on behalf of a processor core. It takes one command at a time: a single compare-and-swap, a dual compare-and-swap over two addresses, or a byte test-and-set. Each command carries its operand size, its address or addresses, the compare values and the update values. The sequencer reads memory over a simple request/acknowledge bus, compares what it read against the compare values, and then either writes the update values or hands the memory values back so the core can load them into its compare registers.

The bus lock rises one cycle before the first read and stays high until the sequence ends. No other master can get in between the read and the write, or between the two halves of the dual form. When the sequence finishes, the block raises a one-cycle completion pulse. In the same cycle it presents the condition codes, a per-operand "load compare register" mask and the values that were read.

Top module: `rmw_atomic_seq`

## Requirements
- R1: `cmd_size` selects the operand size: 0 = 8 bits, 1 = 16 bits, and 2 or 3 = 32 bits. Compare values, update values and read data are used only in their low bits at that size. `bus_wdata` carries the value zero-extended from that size, and `bus_size` repeats the size code during every access.
- R2: `res_ccr` is {N,Z,V,C} (bit 3 down to bit 0). It is set as for the subtraction of the compare value from the memory value at the operand size: N is the sign of the difference, Z means the difference is zero, V is signed overflow and C is the unsigned borrow.
- R3: Compare-and-swap uses `cmd_op` = 0 (code 3 behaves the same). It reads `cmd_addr0`. If the values are equal, it writes the update value to that address and reports `res_load` = 00. Otherwise it performs no write, reports `res_load` = 01 and returns the memory value on `res_val0`.
- R4: Test-and-set uses `cmd_op` = 2. It always works on a byte, whatever `cmd_size` says. Its flags come from comparing the byte with zero, and it always writes the byte back with bit 7 set. It reports `res_load` = 00.
- R5: Dual compare-and-swap uses `cmd_op` = 1. It reads `cmd_addr0` and then `cmd_addr1` before any write. If both compares are equal, it writes update 0 to address 0 and then update 1 to address 1. Otherwise it writes nothing, reports `res_load` = 11 and returns both memory values on `res_val0` and `res_val1`.
- R6: In the dual form, the flags come from the first compare when that compare is unequal, and from the second compare otherwise.
- R7: `bus_lock` is asserted whenever `bus_req` is. It rises one cycle before the first request. It stays high without a gap until the cycle after the final acknowledge, and falls in the same cycle as `done`.
- R8: A request holds `bus_req`, `bus_addr` and `bus_we` steady until `bus_ack` is seen. Any number of wait cycles is allowed.
- R9: `done` is high for exactly one cycle per command, and the results are valid in that cycle.
- R10: `cmd_ready` is high only while the sequencer is idle. A command presented while it is busy is ignored: it causes no bus access and no memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command taken when valid |
| cmd_op | input | 2 | 0 swap, 1 dual swap, 2 test-and-set, 3 as swap |
| cmd_size | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| cmd_addr0 | input | AW | First operand address |
| cmd_addr1 | input | AW | Second operand address (dual form) |
| cmd_cmp0 | input | DW | First compare value |
| cmd_cmp1 | input | DW | Second compare value |
| cmd_upd0 | input | DW | First update value |
| cmd_upd1 | input | DW | Second update value |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_lock | output | 1 | Bus held for this sequence |
| bus_size | output | 2 | Access size code |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with ack |
| bus_ack | input | 1 | Access complete |
| done | output | 1 | Sequence complete pulse |
| res_ccr | output | 4 | Condition codes {N,Z,V,C} |
| res_load | output | 2 | Per operand: load compare register |
| res_val0 | output | DW | First memory value read |
| res_val1 | output | DW | Second memory value read |

## Verification
The bench builds the block with AW = 12 and the default DW = 32, so all three operand sizes are reached. The bench memory deliberately returns junk in the bits above the operand size, which exercises the masking at each width. The bus model runs once with zero wait cycles and once with three. The three-cycle setting brings the request-hold rule into reach, and it stretches each sequence long enough to present a competing command while the lock is held. In the dual form, the tests cover a mismatch on either operand as well as a full match, so the flag-source choice and the all-or-nothing write are both observed.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    OP_CAS  = 2'd0,
    OP_CAS2 = 2'd1,
    OP_TAS  = 2'd2,
    OP_ALT  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_L = 2'd2,
    SZ_X = 2'd3
  } size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/rmw_size_mask.sv
module rmw_size_mask #(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_comb begin
    case (size)
      2'd0:    dout = {{(DW-8){1'b0}}, din[7:0]};
      2'd1:    dout = {{(DW-16){1'b0}}, din[15:0]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/rmw_flag_calc.sv
module rmw_flag_calc
  import rmw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  input  logic [DW-1:0] dest,
  input  logic [DW-1:0] src,
  output ccr_t          flags
);
  logic [DW:0]   wide;
  logic [DW-1:0] diff;
  logic          d_top, s_top, r_top;

  // operands arrive zero-extended from the size, so the top bit is the borrow
  assign wide = {1'b0, dest} - {1'b0, src};

  rmw_size_mask #(.DW(DW)) u_trim (
    .size (size),
    .din  (wide[DW-1:0]),
    .dout (diff)
  );

  always_comb begin
    case (size)
      2'd0: begin
        d_top = dest[7];
        s_top = src[7];
        r_top = diff[7];
      end
      2'd1: begin
        d_top = dest[15];
        s_top = src[15];
        r_top = diff[15];
      end
      default: begin
        d_top = dest[DW-1];
        s_top = src[DW-1];
        r_top = diff[DW-1];
      end
    endcase
    flags.n = r_top;
    flags.z = (diff == '0);
    flags.v = (d_top ^ s_top) & (r_top ^ d_top);
    flags.c = wide[DW];
  end
endmodule

// File: rtl/rmw_atomic_seq.sv
module rmw_atomic_seq
  import rmw_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [1:0]    cmd_size,
  input  logic [AW-1:0] cmd_addr0,
  input  logic [AW-1:0] cmd_addr1,
  input  logic [DW-1:0] cmd_cmp0,
  input  logic [DW-1:0] cmd_cmp1,
  input  logic [DW-1:0] cmd_upd0,
  input  logic [DW-1:0] cmd_upd1,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_lock,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          done,
  output logic [3:0]    res_ccr,
  output logic [1:0]    res_load,
  output logic [DW-1:0] res_val0,
  output logic [DW-1:0] res_val1
);
  localparam int NOPS = 2;
  localparam logic [DW-1:0] SET_BIT7 = {{(DW-8){1'b0}}, 8'h80};

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCK, ST_RD0, ST_RD1, ST_EVAL, ST_WR0, ST_WR1, ST_FIN
  } st_e;

  st_e           st;
  logic [1:0]    op_q, sz_q, sz_in;
  logic [AW-1:0] a_q   [NOPS];
  logic [DW-1:0] c_q   [NOPS];
  logic [DW-1:0] u_q   [NOPS];
  logic [DW-1:0] m_q   [NOPS];
  logic [DW-1:0] cmp_in[NOPS];
  logic [DW-1:0] upd_in[NOPS];
  logic [DW-1:0] cmp_m [NOPS];
  logic [DW-1:0] upd_m [NOPS];
  ccr_t          fl    [NOPS];
  logic [DW-1:0] rd_m;
  ccr_t          ccr_q;

  assign sz_in     = (cmd_op == OP_TAS) ? 2'd0 : cmd_size;
  assign cmp_in[0] = cmd_cmp0;
  assign cmp_in[1] = cmd_cmp1;
  assign upd_in[0] = cmd_upd0;
  assign upd_in[1] = cmd_upd1;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    rmw_size_mask #(.DW(DW)) u_cmp (.size(sz_in), .din(cmp_in[g]), .dout(cmp_m[g]));
    rmw_size_mask #(.DW(DW)) u_upd (.size(sz_in), .din(upd_in[g]), .dout(upd_m[g]));
    rmw_flag_calc #(.DW(DW)) u_flg (.size(sz_q), .dest(m_q[g]), .src(c_q[g]), .flags(fl[g]));
  end

  rmw_size_mask #(.DW(DW)) u_rd (.size(sz_q), .din(bus_rdata), .dout(rd_m));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op_q     <= '0;
      sz_q     <= '0;
      ccr_q    <= '0;
      res_load <= '0;
      res_val0 <= '0;
      res_val1 <= '0;
      for (int i = 0; i < NOPS; i++) begin
        a_q[i] <= '0;
        c_q[i] <= '0;
        u_q[i] <= '0;
        m_q[i] <= '0;
      end
    end else begin
      case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          sz_q   <= sz_in;
          a_q[0] <= cmd_addr0;
          a_q[1] <= cmd_addr1;
          c_q[0] <= (cmd_op == OP_TAS) ? '0 : cmp_m[0];
          c_q[1] <= cmp_m[1];
          u_q[0] <= upd_m[0];
          u_q[1] <= upd_m[1];
          st     <= ST_LOCK;
        end
        ST_LOCK: st <= ST_RD0;
        ST_RD0: if (bus_ack) begin
          m_q[0] <= rd_m;
          st     <= (op_q == OP_CAS2) ? ST_RD1 : ST_EVAL;
        end
        ST_RD1: if (bus_ack) begin
          m_q[1] <= rd_m;
          st     <= ST_EVAL;
        end
        ST_EVAL: begin
          ccr_q    <= (op_q == OP_CAS2 && fl[0].z) ? fl[1] : fl[0];
          res_val0 <= m_q[0];
          res_val1 <= m_q[1];
          if (op_q == OP_TAS) begin
            res_load <= 2'b00;
            st       <= ST_WR0;
          end else if (op_q == OP_CAS2) begin
            res_load <= (fl[0].z && fl[1].z) ? 2'b00 : 2'b11;
            st       <= (fl[0].z && fl[1].z) ? ST_WR0 : ST_FIN;
          end else begin
            res_load <= fl[0].z ? 2'b00 : 2'b01;
            st       <= fl[0].z ? ST_WR0 : ST_FIN;
          end
        end
        ST_WR0: if (bus_ack) st <= (op_q == OP_CAS2) ? ST_WR1 : ST_FIN;
        ST_WR1: if (bus_ack) st <= ST_FIN;
        ST_FIN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign bus_req   = (st == ST_RD0) || (st == ST_RD1) || (st == ST_WR0) || (st == ST_WR1);
  assign bus_we    = (st == ST_WR0) || (st == ST_WR1);
  assign bus_lock  = (st != ST_IDLE) && (st != ST_FIN);
  assign bus_addr  = ((st == ST_RD1) || (st == ST_WR1)) ? a_q[1] : a_q[0];
  assign bus_size  = sz_q;
  assign done      = (st == ST_FIN);
  assign res_ccr   = ccr_q;

  always_comb begin
    if (st == ST_WR1)          bus_wdata = u_q[1];
    else if (op_q == OP_TAS)   bus_wdata = m_q[0] | SET_BIT7;
    else                       bus_wdata = u_q[0];
  end
endmodule

// File: rtl/rmw_atomic_chk.sv
module rmw_atomic_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_ready,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_lock,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack,
  input logic          done
);
  p_req_locked_r7: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_lock);

  p_lock_idle_lead_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_lock) |-> !bus_req);

  p_lock_then_req_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_lock) |=> bus_req);

  p_unlock_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_lock) |-> done);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!bus_lock && !bus_req));
endmodule

bind rmw_atomic_seq rmw_atomic_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_lock  (bus_lock),
  .bus_addr  (bus_addr),
  .bus_ack   (bus_ack),
  .done      (done)
);

// File: tb/rmw_atomic_seq_test.sv
module rmw_atomic_seq_test;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 0;
  logic          rst = 1;
  logic          cmd_valid = 0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 0, cmd_size = 0;
  logic [AW-1:0] cmd_addr0 = 0, cmd_addr1 = 0;
  logic [DW-1:0] cmd_cmp0 = 0, cmd_cmp1 = 0, cmd_upd0 = 0, cmd_upd1 = 0;
  logic          bus_req, bus_we, bus_lock;
  logic [1:0]    bus_size;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = 0;
  logic          bus_ack = 0;
  logic          done;
  logic [3:0]    res_ccr;
  logic [1:0]    res_load;
  logic [DW-1:0] res_val0, res_val1;

  always #5 clk = ~clk;

  rmw_atomic_seq #(.AW(AW), .DW(DW)) uut (.*);

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] mem [0:63];
  int wait_n = 0, wcnt = 0;
  int nlog = 0;
  logic        log_we  [0:15];
  logic [5:0]  log_adr [0:15];
  logic [1:0]  log_sz  [0:15];
  int lock_bad = 0, lead_bad = 0, gap_bad = 0, hold_bad = 0;
  logic lock_prev = 0, req_prev = 0, ack_prev = 0, we_prev = 0;
  logic [AW-1:0] adr_prev = 0;

  logic [3:0]  r_ccr;
  logic [1:0]  r_load;
  logic [31:0] r_v0, r_v1;
  logic        r_ok, r_lock, r_done2, r_rdy;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ccr(int sz, logic [31:0] d, logic [31:0] c);
    int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    longint unsigned m = (64'd1 << w) - 1;
    longint unsigned dd = d & m, cc = c & m, r;
    logic n, z, v, cy, dt, ct;
    r  = (dd - cc) & m;
    n  = r[w-1];
    z  = (r == 0);
    cy = (cc > dd);
    dt = dd[w-1];
    ct = cc[w-1];
    v  = (dt != ct) && (n != dt);
    return {n, z, v, cy};
  endfunction

  // bus model and protocol monitor, all at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && !bus_lock) lock_bad++;
      if (bus_req && !lock_prev) lead_bad++;
      if (lock_prev && !bus_lock && !done) gap_bad++;
      if (req_prev && !ack_prev && (!bus_req || bus_addr !== adr_prev || bus_we !== we_prev)) hold_bad++;
    end
    lock_prev = bus_lock;
    req_prev  = bus_req;
    adr_prev  = bus_addr;
    we_prev   = bus_we;
    if (rst) begin
      bus_ack = 0;
      wcnt = 0;
    end else if (bus_ack) begin
      bus_ack = 0;
      wcnt = 0;
    end else if (bus_req) begin
      if (wcnt < wait_n) wcnt++;
      else begin
        bus_ack = 1;
        if (nlog < 16) begin
          log_we[nlog]  = bus_we;
          log_adr[nlog] = bus_addr[5:0];
          log_sz[nlog]  = bus_size;
        end
        nlog++;
        if (bus_we) mem[bus_addr[5:0]] = bus_wdata;
        else        bus_rdata = mem[bus_addr[5:0]];
      end
    end
    ack_prev = bus_ack;
  end

  task automatic run_cmd(logic [1:0] op, logic [1:0] sz, logic [5:0] a0, logic [5:0] a1,
                         logic [31:0] c0, logic [31:0] c1, logic [31:0] u0, logic [31:0] u1);
    int n = 0;
    nlog = 0;
    @(negedge clk);
    cmd_op = op; cmd_size = sz; cmd_addr0 = AW'(a0); cmd_addr1 = AW'(a1);
    cmd_cmp0 = c0; cmd_cmp1 = c1; cmd_upd0 = u0; cmd_upd1 = u1;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    r_ok = done; r_ccr = res_ccr; r_load = res_load; r_v0 = res_val0; r_v1 = res_val1;
    r_lock = bus_lock;
    @(negedge clk);
    r_done2 = done;
    r_rdy = cmd_ready;
  endtask

  task automatic t_reset;
    check("R10", "ready after reset", cmd_ready, 1);
    check("R7", "lock after reset", {bus_lock, bus_req}, 0);
    check("R9", "done after reset", done, 0);
  endtask

  task automatic t_cas_long;
    mem[4] = 32'h1234_5678;
    run_cmd(0, 2, 4, 0, 32'h1234_5678, 0, 32'hCAFE_F00D, 0);
    check("R9", "done seen", r_ok, 1);
    check("R2", "ccr long hit", r_ccr, exp_ccr(2, 32'h1234_5678, 32'h1234_5678));
    check("R3", "load on hit", r_load, 2'b00);
    check("R3", "mem written", mem[4], 32'hCAFE_F00D);
    check("R3", "access pattern", {nlog[3:0], log_we[0], log_we[1]}, {4'd2, 1'b0, 1'b1});
    check("R9", "done one cycle", r_done2, 0);
    check("R7", "lock low with done", r_lock, 0);
    check("R10", "ready after done", r_rdy, 1);
  endtask

  task automatic t_cas_byte;
    mem[5] = 32'hDEAD_BE80;
    run_cmd(0, 0, 5, 0, 32'hFFFF_FF80, 0, 32'hAAAA_AA11, 0);
    check("R1", "byte compare ignores upper", r_ccr, 4'b0100);
    check("R1", "byte write zero-extended", mem[5], 32'h0000_0011);
    check("R1", "bus size byte", log_sz[1], 2'd0);
  endtask

  task automatic t_cas_word_miss;
    mem[6] = 32'h5555_7000;
    run_cmd(0, 1, 6, 0, 32'h0000_8000, 0, 32'h0000_1111, 0);
    check("R2", "ccr word miss", r_ccr, exp_ccr(1, 32'h7000, 32'h8000));
    check("R2", "ccr word miss literal", r_ccr, 4'b1011);
    check("R3", "load on miss", r_load, 2'b01);
    check("R3", "returned value", r_v0, 32'h0000_7000);
    check("R3", "no write on miss", {nlog[3:0], log_we[0]}, {4'd1, 1'b0});
    check("R3", "mem unchanged", mem[6], 32'h5555_7000);
    mem[8] = 32'h0000_0001;
    run_cmd(3, 2, 8, 0, 32'h8000_0000, 0, 0, 0);
    check("R2", "ccr long overflow", r_ccr, exp_ccr(2, 32'h1, 32'h8000_0000));
  endtask

  task automatic t_tas;
    mem[7] = 32'h0000_0005;
    run_cmd(2, 2, 7, 0, 32'h1234, 0, 32'h5678, 0);
    check("R4", "tas flags positive", r_ccr, 4'b0000);
    check("R4", "tas writes bit7", mem[7], 32'h0000_0085);
    check("R4", "tas byte size on bus", {log_sz[0], log_sz[1]}, 4'b0000);
    check("R4", "tas load", r_load, 2'b00);
    mem[7] = 32'hFFFF_FF80;
    run_cmd(2, 1, 7, 0, 0, 0, 0, 0);
    check("R4", "tas flags negative", r_ccr, 4'b1000);
    check("R4", "tas rewrite", mem[7], 32'h0000_0080);
    mem[7] = 32'h1234_5600;
    run_cmd(2, 0, 7, 0, 0, 0, 0, 0);
    check("R4", "tas flags zero", r_ccr, 4'b0100);
    check("R4", "tas from zero", mem[7], 32'h0000_0080);
  endtask

  task automatic t_cas2_hit;
    mem[10] = 32'h1111_2222; mem[11] = 32'h3333_4444;
    run_cmd(1, 2, 10, 11, 32'h1111_2222, 32'h3333_4444, 32'hAAAA_0001, 32'hBBBB_0002);
    check("R5", "dual order", {nlog[3:0], log_we[0], log_adr[0], log_we[1], log_adr[1],
          log_we[2], log_adr[2], log_we[3], log_adr[3]},
          {4'd4, 1'b0, 6'd10, 1'b0, 6'd11, 1'b1, 6'd10, 1'b1, 6'd11});
    check("R5", "dual mem0", mem[10], 32'hAAAA_0001);
    check("R5", "dual mem1", mem[11], 32'hBBBB_0002);
    check("R6", "dual hit flags", r_ccr, 4'b0100);
    check("R5", "dual hit load", r_load, 2'b00);
  endtask

  task automatic t_cas2_miss;
    mem[12] = 32'h0000_0010; mem[13] = 32'h0000_0040;
    run_cmd(1, 1, 12, 13, 32'h20, 32'h40, 32'h99, 32'h98);
    check("R6", "flags from first", r_ccr, exp_ccr(1, 32'h10, 32'h20));
    check("R5", "load both", r_load, 2'b11);
    check("R5", "returned pair", {r_v0, r_v1}, {32'h10, 32'h40});
    check("R5", "no writes", {nlog[3:0], mem[12], mem[13]}, {4'd2, 32'h10, 32'h40});
    run_cmd(1, 0, 12, 13, 32'h10, 32'h7F, 32'h99, 32'h98);
    check("R6", "flags from second", r_ccr, exp_ccr(0, 32'h40, 32'h7F));
    check("R5", "second miss no writes", {nlog[3:0], mem[12], mem[13]}, {4'd2, 32'h10, 32'h40});
  endtask

  task automatic t_busy;
    int n = 0;
    logic rdy_seen = 0;
    wait_n = 3;
    mem[20] = 32'h77; mem[21] = 32'h5;
    nlog = 0;
    @(negedge clk);
    cmd_op = 0; cmd_size = 2; cmd_addr0 = 21; cmd_cmp0 = 32'h5; cmd_upd0 = 32'h6;
    cmd_valid = 1;
    @(negedge clk);
    cmd_addr0 = 20; cmd_cmp0 = 32'h77; cmd_upd0 = 32'h99;
    for (int i = 0; i < 4; i++) begin
      rdy_seen |= cmd_ready;
      @(negedge clk);
    end
    cmd_valid = 0;
    check("R10", "ready low while busy", rdy_seen, 0);
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    check("R10", "first command done", {done, mem[21]}, {1'b1, 32'h6});
    repeat (8) @(negedge clk);
    check("R10", "intruder ignored", {nlog[3:0], mem[20], bus_lock}, {4'd2, 32'h77, 1'b0});
    mem[22] = 32'h3;
    run_cmd(1, 2, 22, 21, 32'h3, 32'h6, 32'h30, 32'h60);
    check("R8", "waited dual writes", {mem[22], mem[21]}, {32'h30, 32'h60});
    wait_n = 0;
  endtask

  task automatic t_protocol;
    check("R7", "req without lock", lock_bad, 0);
    check("R7", "req in lock rise cycle", lead_bad, 0);
    check("R7", "lock gap", gap_bad, 0);
    check("R8", "request not held", hold_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5A5_0000 + i;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cas_long();
    t_cas_byte();
    t_cas_word_miss();
    t_tas();
    t_cas2_hit();
    t_cas2_miss();
    t_busy();
    t_protocol();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule